// File: doc/BRIEF.md
# Burst Bus Master Sequencer

This block is the master-side phase controller for a shared, multiplexed address/data bus. An internal requester presents an access (address, read or write, a length of one to four words, and an atomic-sequence flag). The sequencer walks the bus through an address cycle, a wait/data phase with one or more words, and a recovery phase. It also decides when an external agent may take the bus. A single ready input from the addressed device does double duty: while it is high in the data phase it retires a word, and only its return to low closes recovery.

Ownership is traded against an external hold request, which is granted only at decision points (idle, end of recovery) and never while an atomic sequence holds the lock. A test isolation state parks the sequencer with its bus outputs released. It is entered when the isolation input is high in the first cycle after reset and left only by another reset.

Top module: `burst_bus_seq`

## Requirements
- R1: While `rst` is high, `state_o` reads idle (code 0), `req_accept_o`, `last_o` and `hold_ack_o` are 0, and a pending request is not taken.
- R2: If `isol_i` is high in the first cycle after `rst` falls, `state_o` becomes 5 (isolation) and stays 5 until the next reset, with `drive_en_o` low and no request accepted.
- R3: From idle, a pending request with no hold request, or with the lock active, pulses `req_accept_o` in that cycle. `state_o` then shows 1 (address) for exactly one cycle with `bus_addr_o` equal to the captured address, followed by 2 (wait/data).
- R4: In wait/data, each cycle with `rdy_i` high completes one word and advances `beat_o` (0 for the first word). With `rdy_i` low the state and `beat_o` hold for as long as it stays low.
- R5: `req_len_i` encodes the word count minus one (0 = one word, 3 = four words). `last_o` is high exactly during the wait/data cycles of the final word.
- R6: `rdy_i` high while `last_o` is high moves the state to 3 (recovery). Recovery lasts as long as `rdy_i` stays high.
- R7: On the cycle recovery ends (`rdy_i` low), the next state is hold if `hold_req_i` is high and no lock is active, else address if a request is pending, else idle.
- R8: From idle, `hold_req_i` high with no lock active and no lock-qualified request moves the state to 4 (hold). Hold persists while `hold_req_i` is high. On release the next state is address if a request is pending, else idle.
- R9: `hold_ack_o` is high only in hold. `drive_en_o` is low in hold and isolation, and `bus_addr_o` and `bus_write_o` are 0 whenever `drive_en_o` is low.
- R10: `req_lock_i` is captured with each accepted request. While the last captured value is 1, a hold request is refused at idle and at the end of recovery. The lock clears once a request with `req_lock_i` low has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isol_i | input | 1 | Isolation request, sampled in the first cycle after reset |
| req_valid_i | input | 1 | Access pending; held until accepted |
| req_addr_i | input | ADDR_W | Access start address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_len_i | input | LEN_W | Word count minus one |
| req_lock_i | input | 1 | Access belongs to an atomic sequence that keeps the bus |
| req_accept_o | output | 1 | Request taken this cycle |
| rdy_i | input | 1 | Device ready: ends a word, its release ends recovery |
| hold_req_i | input | 1 | External bus ownership request |
| hold_ack_o | output | 1 | Bus handed to the external agent |
| state_o | output | 3 | Phase code: 0 idle, 1 address, 2 wait/data, 3 recovery, 4 hold, 5 isolation |
| drive_en_o | output | 1 | Bus outputs driven by this master |
| bus_addr_o | output | ADDR_W | Captured address, 0 when not driving |
| bus_write_o | output | 1 | Captured direction, 0 when not driving |
| beat_o | output | LEN_W | Index of the current word in the burst |
| last_o | output | 1 | Current word is the final one |

## Verification
The most delicate coincidence is the end of recovery, where a hold request and a pending request arrive together. Here the lock decides whether ownership is handed over or the next locked access starts. A second is `rdy_i` staying high from the final word straight into recovery, where the same level must first retire the word and then hold recovery open. Directed sequences create both cases on purpose, and a long constrained-random run with hold, ready and locked requests toggling creates them many more times. Every cycle, each output is compared with a cycle model in the bench that follows the requirements.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_RECOV = 3'd3,
        ST_HOLD  = 3'd4,
        ST_ISOL  = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic write;
        logic lock;
    } req_ctl_t;

    function automatic logic bus_released(bus_state_e s);
        return (s == ST_HOLD) || (s == ST_ISOL);
    endfunction

    function automatic logic hold_wins(logic hold, logic lock);
        return hold && !lock;
    endfunction

endpackage

// File: rtl/bbs_next_state.sv
module bbs_next_state
    import bbs_pkg::*;
(
    input  bus_state_e st_i,
    input  logic       first_i,
    input  logic       isol_i,
    input  logic       req_i,
    input  logic       hold_i,
    input  logic       lock_i,
    input  logic       rdy_i,
    input  logic       last_i,
    output bus_state_e nxt_o
);
    always_comb begin
        nxt_o = st_i;
        unique case (st_i)
            ST_IDLE: begin
                if (first_i && isol_i)
                    nxt_o = ST_ISOL;
                else if (req_i && !hold_wins(hold_i, lock_i))
                    nxt_o = ST_ADDR;
                else if (hold_wins(hold_i, lock_i))
                    nxt_o = ST_HOLD;
                else
                    nxt_o = ST_IDLE;
            end
            ST_ADDR:  nxt_o = ST_DATA;
            ST_DATA:  nxt_o = (rdy_i && last_i) ? ST_RECOV : ST_DATA;
            ST_RECOV: begin
                if (rdy_i)
                    nxt_o = ST_RECOV;
                else if (hold_wins(hold_i, lock_i))
                    nxt_o = ST_HOLD;
                else if (req_i)
                    nxt_o = ST_ADDR;
                else
                    nxt_o = ST_IDLE;
            end
            ST_HOLD: begin
                if (hold_i)
                    nxt_o = ST_HOLD;
                else if (req_i)
                    nxt_o = ST_ADDR;
                else
                    nxt_o = ST_IDLE;
            end
            ST_ISOL:  nxt_o = ST_ISOL;
            default:  nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bbs_req_reg.sv
module bbs_req_reg
    import bbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  req_ctl_t          ctl_i,
    output logic [ADDR_W-1:0] addr_o,
    output req_ctl_t          ctl_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            ctl_o  <= '0;
        end else if (load_i) begin
            addr_o <= addr_i;
            ctl_o  <= ctl_i;
        end
    end
endmodule

// File: rtl/bbs_beat_ctr.sv
module bbs_beat_ctr #(
    parameter int unsigned LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             in_data_i,
    input  logic             rdy_i,
    output logic [LEN_W-1:0] beat_o,
    output logic             final_o
);
    logic [LEN_W-1:0] remain_q;
    logic             step;

    assign final_o = (remain_q == '0);
    assign step    = in_data_i && rdy_i && !final_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            beat_o   <= '0;
        end else if (load_i) begin
            remain_q <= len_i;
            beat_o   <= '0;
        end else if (step) begin
            remain_q <= remain_q - 1'b1;
            beat_o   <= beat_o + 1'b1;
        end
    end
endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
    import bbs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_WORDS = 4,
    localparam int unsigned LEN_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              isol_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_write_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic              req_lock_i,
    output logic              req_accept_o,
    input  logic              rdy_i,
    input  logic              hold_req_i,
    output logic              hold_ack_o,
    output logic [2:0]        state_o,
    output logic              drive_en_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_write_o,
    output logic [LEN_W-1:0]  beat_o,
    output logic              last_o
);
    bus_state_e        state_q, state_d;
    logic              first_q;
    logic              load;
    logic              lock_act;
    logic              final_word;
    logic [ADDR_W-1:0] addr_q;
    req_ctl_t          ctl_q, ctl_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            first_q <= 1'b0;
        end
    end

    bbs_next_state u_next (
        .st_i    (state_q),
        .first_i (first_q),
        .isol_i  (isol_i),
        .req_i   (req_valid_i),
        .hold_i  (hold_req_i),
        .lock_i  (lock_act),
        .rdy_i   (rdy_i),
        .last_i  (final_word),
        .nxt_o   (state_d)
    );

    assign load          = !rst && (state_d == ST_ADDR) && (state_q != ST_ADDR);
    assign ctl_in.write  = req_write_i;
    assign ctl_in.lock   = req_lock_i;
    assign lock_act      = ctl_q.lock;

    bbs_req_reg #(.ADDR_W(ADDR_W)) u_req (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .addr_i (req_addr_i),
        .ctl_i  (ctl_in),
        .addr_o (addr_q),
        .ctl_o  (ctl_q)
    );

    bbs_beat_ctr #(.LEN_W(LEN_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .len_i     (req_len_i),
        .in_data_i (state_q == ST_DATA),
        .rdy_i     (rdy_i),
        .beat_o    (beat_o),
        .final_o   (final_word)
    );

    assign req_accept_o = load;
    assign state_o      = state_q;
    assign hold_ack_o   = (state_q == ST_HOLD);
    assign drive_en_o   = !bus_released(state_q);
    assign bus_addr_o   = drive_en_o ? addr_q : '0;
    assign bus_write_o  = drive_en_o && ctl_q.write;
    assign last_o       = (state_q == ST_DATA) && final_word;

endmodule

// File: rtl/burst_bus_seq_chk.sv
module burst_bus_seq_chk
    import bbs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] state_o,
    input logic       rdy_i,
    input logic       last_o,
    input logic       hold_ack_o,
    input logic       drive_en_o,
    input logic       req_accept_o,
    input logic       lock_act
);
    AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_ADDR |=> state_o == ST_DATA); // R3
    AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        req_accept_o |=> state_o == ST_ADDR); // R3
    AST_DATA_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DATA && !rdy_i) |=> state_o == ST_DATA); // R4
    AST_LAST_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        last_o |-> state_o == ST_DATA); // R5
    AST_LAST_TO_RECOV: assert property (@(posedge clk) disable iff (rst)
        (last_o && rdy_i) |=> state_o == ST_RECOV); // R6
    AST_RECOV_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RECOV && rdy_i) |=> state_o == ST_RECOV); // R6
    AST_ISOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_ISOL |=> state_o == ST_ISOL); // R2
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> !drive_en_o); // R9
    AST_LOCK_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o != ST_HOLD && lock_act) |=> state_o != ST_HOLD); // R10
endmodule

bind burst_bus_seq burst_bus_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .state_o      (state_o),
    .rdy_i        (rdy_i),
    .last_o       (last_o),
    .hold_ack_o   (hold_ack_o),
    .drive_en_o   (drive_en_o),
    .req_accept_o (req_accept_o),
    .lock_act     (lock_act)
);

// File: tb/burst_bus_seq_tb_top.sv
module burst_bus_seq_tb_top;
    localparam int AW = 32;
    localparam int LW = 2;
    localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_DATA = 3'd2,
                           S_RECOV = 3'd3, S_HOLD = 3'd4, S_ISOL = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic isol = 1'b0, req = 1'b0, wr = 1'b0, lk = 1'b0, rdy = 1'b0, hold = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] len = '0;
    logic acc, hack, den, bwr, last;
    logic [2:0] st;
    logic [AW-1:0] baddr;
    logic [LW-1:0] beat;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // cycle model
    logic [2:0]    m_st = S_IDLE;
    logic          m_first = 1'b1, m_lock = 1'b0, m_wr = 1'b0, m_took = 1'b0;
    logic [LW-1:0] m_rem = '0, m_beat = '0;
    logic [AW-1:0] m_addr = '0;

    always #5 clk = ~clk;

    burst_bus_seq #(.ADDR_W(AW), .MAX_WORDS(4)) dut_i (
        .clk(clk), .rst(rst), .isol_i(isol), .req_valid_i(req), .req_addr_i(addr),
        .req_write_i(wr), .req_len_i(len), .req_lock_i(lk), .req_accept_o(acc),
        .rdy_i(rdy), .hold_req_i(hold), .hold_ack_o(hack), .state_o(st),
        .drive_en_o(den), .bus_addr_o(baddr), .bus_write_o(bwr), .beat_o(beat),
        .last_o(last)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_next();
        logic hw = hold && !m_lock;
        case (m_st)
            S_IDLE:  return (m_first && isol) ? S_ISOL : (req && !hw) ? S_ADDR : hw ? S_HOLD : S_IDLE;
            S_ADDR:  return S_DATA;
            S_DATA:  return (rdy && m_rem == 0) ? S_RECOV : S_DATA;
            S_RECOV: return rdy ? S_RECOV : hw ? S_HOLD : req ? S_ADDR : S_IDLE;
            S_HOLD:  return hold ? S_HOLD : req ? S_ADDR : S_IDLE;
            default: return S_ISOL;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            S_IDLE: return "R3"; S_ADDR: return "R3"; S_DATA: return "R4";
            S_RECOV: return "R7"; S_HOLD: return "R8"; default: return "R2";
        endcase
    endfunction

    // compare all outputs with the model, then advance one clock
    task automatic cycle();
        logic [2:0] nx;
        logic       e_acc, e_den;
        #1;
        nx    = rst ? S_IDLE : exp_next();
        e_acc = !rst && nx == S_ADDR && m_st != S_ADDR;
        e_den = !(m_st == S_HOLD || m_st == S_ISOL);
        chk(rst ? "R1" : tag_of(m_st), "state", st, m_st);
        chk(rst ? "R1" : "R3", "accept", acc, e_acc);
        chk("R5", "last", last, m_st == S_DATA && m_rem == 0);
        chk("R9", "hold_ack", hack, m_st == S_HOLD);
        chk("R9", "drive_en", den, e_den);
        chk("R9", "bus_addr", baddr, e_den ? m_addr : 0);
        chk("R9", "bus_write", bwr, e_den && m_wr);
        if (m_st == S_DATA) chk("R4", "beat", beat, m_beat);
        @(posedge clk);
        m_took = e_acc;
        if (rst) begin
            m_st = S_IDLE; m_first = 1; m_lock = 0; m_wr = 0; m_addr = '0; m_rem = '0; m_beat = '0;
        end else begin
            if (e_acc) begin
                m_addr = addr; m_wr = wr; m_lock = lk; m_rem = len; m_beat = '0;
            end else if (m_st == S_DATA && rdy && m_rem != 0) begin
                m_rem--; m_beat++;
            end
            m_st = nx; m_first = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset(logic iso);
        rst = 1; isol = iso;
        repeat (3) cycle();
        rst = 0;
    endtask

    task automatic put_req(logic [AW-1:0] a, logic w, logic [LW-1:0] n, logic l);
        req = 1; addr = a; wr = w; len = n; lk = l;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        @(negedge clk);
        // R1: request pending during reset is not taken
        put_req(32'hA000_0010, 1, 2'd0, 0);
        do_reset(0);
        chk("R1", "state after reset", st, S_IDLE);

        // R3 single word write, immediate ready
        rdy = 0; cycle();                       // idle, accept
        req = 0; chk("R3", "address phase", st, S_ADDR); cycle();
        chk("R3", "data after address", st, S_DATA);
        chk("R5", "single word is last", last, 1);
        rdy = 1; cycle();
        chk("R6", "recovery entered", st, S_RECOV);
        cycle(); cycle();                       // R6 stretched by ready high
        chk("R6", "recovery held by ready", st, S_RECOV);
        rdy = 0; cycle();
        chk("R7", "idle after recovery", st, S_IDLE);

        // R4/R5 four-word burst with wait cycles
        put_req(32'hB000_0000, 0, 2'd3, 0); cycle(); req = 0; cycle();
        for (int i = 0; i < 4; i++) begin
            rdy = 0; cycle();
            chk("R4", "waiting holds beat", beat, i);
            chk("R5", "last only on final word", last, i == 3);
            rdy = 1; cycle();
        end
        chk("R6", "burst ends in recovery", st, S_RECOV);
        // R7: hold and request together at end of recovery, no lock
        hold = 1; put_req(32'hC000_0000, 1, 2'd1, 1); rdy = 0; cycle();
        chk("R7", "hold wins at recovery end", st, S_HOLD);
        cycle(); chk("R8", "hold persists", hack, 1);
        hold = 0; cycle();
        chk("R8", "release to address", st, S_ADDR);
        // R10 locked access; hold raised and kept
        req = 0; hold = 1; rdy = 1; cycle();
        cycle(); cycle();                       // two words
        put_req(32'hC000_0100, 0, 2'd0, 0); rdy = 0; cycle();
        chk("R10", "locked: request beats hold", st, S_ADDR);
        req = 0; cycle(); rdy = 1; cycle(); rdy = 0; cycle();
        chk("R10", "lock cleared: hold granted", st, S_HOLD);
        hold = 0; cycle();
        chk("R8", "release to idle", st, S_IDLE);
        // R10 lock left active in idle refuses hold
        put_req(32'hD000_0000, 0, 2'd0, 1); cycle(); req = 0; cycle();
        rdy = 1; cycle(); rdy = 0; cycle();
        hold = 1; cycle(); cycle();
        chk("R10", "idle lock refuses hold", st, S_IDLE);
        put_req(32'hD000_0040, 1, 2'd0, 0); cycle();
        chk("R3", "locked idle takes request despite hold", st, S_ADDR);
        req = 0; rdy = 1; cycle(); cycle(); rdy = 0; cycle();
        chk("R8", "hold from recovery once unlocked", st, S_HOLD);
        hold = 0; cycle();

        // R2 isolation
        do_reset(1);
        put_req(32'hE000_0000, 1, 2'd2, 0); hold = 1; cycle();
        for (int i = 0; i < 6; i++) begin
            isol = 0; hold = i[0]; cycle();
        end
        chk("R2", "isolation sticky", st, S_ISOL);
        chk("R2", "isolation releases bus", den, 0);
        req = 0; hold = 0;
        do_reset(0);
        chk("R2", "reset leaves isolation", st, S_IDLE);

        // random run
        for (int n = 0; n < 4000; n++) begin
            if (m_took) req = 0;
            if (!req && ($urandom % 3 == 0))
                put_req($urandom, $urandom % 2, $urandom % 4, ($urandom % 4) == 0);
            rdy  = ($urandom % 10) < 6;
            hold = ($urandom % 10) < 2;
            cycle();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule